// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects level-sensitive interrupt requests and chooses the one a processor should service next. Each input has an enable bit and a configuration word that holds a priority level, a non-maskable flag and a register-set number. Each input also has a handler address. Among the requests that are pending and enabled, the one with the highest level wins. The winner's level, flag, register set and handler address are handed to the processor through a valid/ready output stream.

A request from an upstream controller of the same kind can be merged in through a chain input. It takes part in arbitration only when a control bit allows it. A small word-addressed register port reaches the enable, control, configuration and handler-address storage, and a read-only vector register. The vector register shows the live winner's handler address. Slots for inputs that the build leaves out read as zero and ignore writes, so software can find out which inputs exist by writing all ones and reading the value back.

The output stream follows the usual back-pressure rule. Once `out_valid` is high, the valid flag and every payload field stay unchanged until a cycle in which `out_ready` is high. While no transfer is outstanding, or in a cycle where one completes, the stage takes a new sample of the arbitration result.

Top module: `vec_irq_prio`

## Requirements
- R1: The enable register (word address 0x00) has one bit per input, and bit i enables input i. Bits at positions NUM_IRQ and above always read 0 and ignore writes. Configuration and handler-address words of inputs that do not exist also read 0 and ignore writes.
- R2: The configuration word of input i sits at word address 0x20+i. Bits 5:0 hold the level, bit 6 holds the non-maskable flag (1 means non-maskable), and bits 12:7 hold the register set. Bits 31:13 read 0. The handler address of input i sits at 0x40+i.
- R3: A read issued with `reg_rd` in one cycle gives `reg_rvalid` high in the next cycle, with the data on `reg_rdata`. `reg_rvalid` is low in every other cycle.
- R4: Input i is pending only when `irq_i[i]` is high, enable bit i is set and its configured level is not 0.
- R5: Among the pending inputs, the highest level wins. When levels are equal, the lower-numbered input wins.
- R6: The vector register (word address 0x02, read-only) reads the handler address of the current winner. It reads 0 when nothing is pending.
- R7: The chain request competes only when bit 0 of the control register (word address 0x01) is set, `chain_valid` is high and `chain_level` is not 0. It wins only when its level is strictly greater than the best local level. When it wins, the vector register and the output stream carry the chain's fields.
- R8: `irq_pending` is high in exactly those cycles in which some local input or the chain request is pending.
- R9: When no transfer is held, `out_valid` and the payload (`out_level`, `out_nmi`, `out_rset`, `out_haddr`) take, one cycle later, the pending status and the winner's fields of the current cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and every payload field hold their values.
- R11: After reset, every register reads 0, and `out_valid` and `irq_pending` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt requests |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| chain_valid | input | 1 | Upstream chain request present |
| chain_level | input | 6 | Chain request level |
| chain_nmi | input | 1 | Chain request non-maskable flag |
| chain_rset | input | 6 | Chain request register set |
| chain_haddr | input | 32 | Chain request handler address |
| irq_pending | output | 1 | Some enabled request is pending |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready (processor acknowledge) |
| out_level | output | 6 | Winning level |
| out_nmi | output | 1 | Winning non-maskable flag |
| out_rset | output | 6 | Winning register set |
| out_haddr | output | 32 | Winning handler address |

## Verification
The assertions assume that the processor drives `out_ready` as a plain level and never assumes the payload changes while a transfer is held. They also assume that `reg_rd` and `reg_wr` are never raised for the same address in one cycle. The stimulus raises only one of the two strobes in any cycle. It changes requests, strobes and ready only at the falling clock edge, so every input is steady at the rising edge that samples it.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int MAX_IRQ = 32;
  localparam int LVL_W   = 6;
  localparam int RS_W    = 6;
  localparam int HA_W    = 32;
  localparam int DAT_W   = 32;
  localparam int ADR_W   = 7;
  localparam int CFG_W   = LVL_W + 1 + RS_W;
  localparam int IDX_W   = $clog2(MAX_IRQ);

  localparam logic [ADR_W-1:0] A_EN   = 7'h00;
  localparam logic [ADR_W-1:0] A_CTRL = 7'h01;
  localparam logic [ADR_W-1:0] A_VEC  = 7'h02;
  localparam logic [1:0]       PG_CFG = 2'b01;
  localparam logic [1:0]       PG_HA  = 2'b10;

  typedef struct packed {
    logic             act;
    logic [LVL_W-1:0] lvl;
    logic             nmi;
    logic [RS_W-1:0]  rset;
    logic [HA_W-1:0]  haddr;
  } cand_t;
endpackage

// File: rtl/vip_regs.sv
module vip_regs
  import vip_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADR_W-1:0]                addr,
  input  logic [DAT_W-1:0]                wdata,
  input  logic [HA_W-1:0]                 vec_addr,
  output logic [DAT_W-1:0]                rdata,
  output logic                            rvalid,
  output logic [NUM_IRQ-1:0]              en_q,
  output logic [NUM_IRQ-1:0][CFG_W-1:0]   cfg_q,
  output logic [NUM_IRQ-1:0][HA_W-1:0]    ha_q,
  output logic                            chain_en_q
);
  localparam int PAD_W = DAT_W - CFG_W;

  logic [1:0]       page;
  logic [IDX_W-1:0] idx;
  assign page = addr[ADR_W-1:ADR_W-2];
  assign idx  = addr[IDX_W-1:0];

  logic [MAX_IRQ-1:0] en_full;
  logic [CFG_W-1:0]   cfg_full [MAX_IRQ];
  logic [HA_W-1:0]    ha_full  [MAX_IRQ];

  for (genvar g = 0; g < MAX_IRQ; g++) begin : g_slot
    if (g < NUM_IRQ) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_q[g]  <= 1'b0;
          cfg_q[g] <= '0;
          ha_q[g]  <= '0;
        end else if (wr_en) begin
          if (addr == A_EN)                            en_q[g]  <= wdata[g];
          if (page == PG_CFG && idx == IDX_W'(g))      cfg_q[g] <= wdata[CFG_W-1:0];
          if (page == PG_HA  && idx == IDX_W'(g))      ha_q[g]  <= wdata[HA_W-1:0];
        end
      end
      assign en_full[g]  = en_q[g];
      assign cfg_full[g] = cfg_q[g];
      assign ha_full[g]  = ha_q[g];
    end else begin : g_absent
      assign en_full[g]  = 1'b0;
      assign cfg_full[g] = '0;
      assign ha_full[g]  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        chain_en_q <= 1'b0;
    else if (wr_en && addr == A_CTRL)  chain_en_q <= wdata[0];
  end

  logic [DAT_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (addr == A_EN)          rd_word = DAT_W'(en_full);
    else if (addr == A_CTRL)   rd_word = DAT_W'(chain_en_q);
    else if (addr == A_VEC)    rd_word = DAT_W'(vec_addr);
    else if (page == PG_CFG)   rd_word = {{PAD_W{1'b0}}, cfg_full[idx]};
    else if (page == PG_HA)    rd_word = DAT_W'(ha_full[idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/vip_arb.sv
module vip_arb
  import vip_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0]            irq,
  input  logic [NUM_IRQ-1:0]            en,
  input  logic [NUM_IRQ-1:0][CFG_W-1:0] cfg,
  input  logic [NUM_IRQ-1:0][HA_W-1:0]  ha,
  input  logic                          chain_en,
  input  logic                          chain_valid,
  input  logic [LVL_W-1:0]              chain_level,
  input  logic                          chain_nmi,
  input  logic [RS_W-1:0]               chain_rset,
  input  logic [HA_W-1:0]               chain_haddr,
  output cand_t                         win
);
  cand_t loc [NUM_IRQ];
  cand_t chn;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cand
    assign loc[g].lvl   = cfg[g][LVL_W-1:0];
    assign loc[g].nmi   = cfg[g][LVL_W];
    assign loc[g].rset  = cfg[g][CFG_W-1:LVL_W+1];
    assign loc[g].haddr = ha[g];
    assign loc[g].act   = irq[g] && en[g] && (cfg[g][LVL_W-1:0] != '0);
  end

  assign chn.act   = chain_en && chain_valid && (chain_level != '0);
  assign chn.lvl   = chain_level;
  assign chn.nmi   = chain_nmi;
  assign chn.rset  = chain_rset;
  assign chn.haddr = chain_haddr;

  // Strict comparison keeps the earliest (lowest index) entry on ties;
  // the chain is scanned last so it only wins with a greater level.
  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (loc[i].act && loc[i].lvl > win.lvl) win = loc[i];
    end
    if (chn.act && chn.lvl > win.lvl) win = chn;
  end
endmodule

// File: rtl/vip_out.sv
module vip_out
  import vip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cand_t             win,
  input  logic              ready,
  output logic              valid,
  output logic [LVL_W-1:0]  level,
  output logic              nmi,
  output logic [RS_W-1:0]   rset,
  output logic [HA_W-1:0]   haddr
);
  logic load;
  assign load = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      level <= '0;
      nmi   <= 1'b0;
      rset  <= '0;
      haddr <= '0;
    end else if (load) begin
      valid <= win.act;
      level <= win.lvl;
      nmi   <= win.nmi;
      rset  <= win.rset;
      haddr <= win.haddr;
    end
  end
endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio
  import vip_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [6:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid,
  input  logic               chain_valid,
  input  logic [5:0]         chain_level,
  input  logic               chain_nmi,
  input  logic [5:0]         chain_rset,
  input  logic [31:0]        chain_haddr,
  output logic               irq_pending,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [5:0]         out_level,
  output logic               out_nmi,
  output logic [5:0]         out_rset,
  output logic [31:0]        out_haddr
);
  logic [NUM_IRQ-1:0]            en_q;
  logic [NUM_IRQ-1:0][CFG_W-1:0] cfg_q;
  logic [NUM_IRQ-1:0][HA_W-1:0]  ha_q;
  logic                          chain_en_q;
  cand_t                         win;

  vip_regs #(.NUM_IRQ(NUM_IRQ)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .vec_addr(win.haddr),
    .rdata(reg_rdata), .rvalid(reg_rvalid), .en_q(en_q), .cfg_q(cfg_q),
    .ha_q(ha_q), .chain_en_q(chain_en_q)
  );

  vip_arb #(.NUM_IRQ(NUM_IRQ)) arb_i (
    .irq(irq_i), .en(en_q), .cfg(cfg_q), .ha(ha_q),
    .chain_en(chain_en_q), .chain_valid(chain_valid),
    .chain_level(chain_level), .chain_nmi(chain_nmi),
    .chain_rset(chain_rset), .chain_haddr(chain_haddr), .win(win)
  );

  vip_out out_i (
    .clk(clk), .rst_n(rst_n), .win(win), .ready(out_ready),
    .valid(out_valid), .level(out_level), .nmi(out_nmi),
    .rset(out_rset), .haddr(out_haddr)
  );

  assign irq_pending = win.act;
endmodule

// File: rtl/vip_chk.sv
module vip_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_rd,
  input logic        reg_rvalid,
  input logic [6:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        irq_pending,
  input logic        out_valid,
  input logic        out_ready,
  input logic [5:0]  out_level,
  input logic        out_nmi,
  input logic [5:0]  out_rset,
  input logic [31:0] out_haddr
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_level) &&
      $stable(out_nmi) && $stable(out_rset) && $stable(out_haddr));

  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  p_no_stray_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  p_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid || out_ready |=> out_valid == $past(irq_pending));

  p_level_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_level != 6'd0);

  p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 7'h02 && !irq_pending |=> reg_rdata == 32'd0);
endmodule

bind vec_irq_prio vip_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rvalid(reg_rvalid),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_pending(irq_pending),
  .out_valid(out_valid), .out_ready(out_ready), .out_level(out_level),
  .out_nmi(out_nmi), .out_rset(out_rset), .out_haddr(out_haddr)
);

// File: tb/vec_irq_prio_tb_top.sv
`timescale 1ns/1ps
module vec_irq_prio_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        chain_valid = 1'b0;
  logic [5:0]  chain_level = '0;
  logic        chain_nmi = 1'b0;
  logic [5:0]  chain_rset = '0;
  logic [31:0] chain_haddr = '0;
  logic        irq_pending, out_valid;
  logic        out_ready = 1'b1;
  logic [5:0]  out_level, out_rset;
  logic        out_nmi;
  logic [31:0] out_haddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  vec_irq_prio #(.NUM_IRQ(N)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Scoreboard monitor: pops one expected word per returned read.
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected rvalid", reg_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(reg_rdata == e, t, reg_rdata, e);
      end
    end
  end

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11 out_valid", 32'(out_valid), 32'h0);
    chk(irq_pending == 1'b0, "R11 irq_pending", 32'(irq_pending), 32'h0);
    rd(7'h00, 32'h0, "R11 enable reset");
    rd(7'h01, 32'h0, "R11 control reset");
    rd(7'h02, 32'h0, "R6 vector idle after reset");

    // R1 probe of present inputs
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, 32'h0000_00FF, "R1 enable probe");
    wr(7'h2A, 32'hFFFF_FFFF);
    rd(7'h2A, 32'h0, "R1 absent config slot");
    wr(7'h4C, 32'h1234_5678);
    rd(7'h4C, 32'h0, "R1 absent handler slot");

    // R2 config field layout, reserved bits read 0
    wr(7'h23, 32'hFFFF_FFFF);
    rd(7'h23, 32'h0000_1FFF, "R2 config width");
    wr(7'h20, 32'h0000_0005);
    wr(7'h21, 32'h0000_0045);
    wr(7'h22, 32'h0000_0189);
    wr(7'h23, 32'h0000_0000);
    for (int i = 0; i < N; i++) wr(7'(7'h40 + i), 32'h1000 + 32'(i) * 32'h10);
    rd(7'h42, 32'h0000_1020, "R2 handler readback");

    // R4 level 0 never requests
    @(negedge clk); irq_i = 8'b0000_1000;
    #1 chk(irq_pending == 1'b0, "R4 level zero idle", 32'(irq_pending), 32'h0);
    rd(7'h02, 32'h0, "R6 vector with no pending");

    // R5 tie goes to lower index
    @(negedge clk); irq_i = 8'b0000_0011;
    #1 chk(irq_pending == 1'b1, "R8 pending high", 32'(irq_pending), 32'h1);
    rd(7'h02, 32'h0000_1000, "R5 tie lower index");

    // R5 higher level wins
    @(negedge clk); irq_i = 8'b0000_0111;
    rd(7'h02, 32'h0000_1020, "R5 higher level");
    settle();
    // R9 payload of winner
    chk(out_valid == 1'b1, "R9 valid", 32'(out_valid), 32'h1);
    chk(out_level == 6'd9, "R9 level", 32'(out_level), 32'd9);
    chk(out_rset == 6'd3, "R9 rset", 32'(out_rset), 32'd3);
    chk(out_haddr == 32'h1020, "R9 haddr", out_haddr, 32'h1020);

    // R10 hold under back-pressure
    @(negedge clk); out_ready = 1'b0;
    @(negedge clk); irq_i = 8'b0000_0010;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid held", 32'(out_valid), 32'h1);
    chk(out_haddr == 32'h1020, "R10 haddr held", out_haddr, 32'h1020);
    chk(out_level == 6'd9, "R10 level held", 32'(out_level), 32'd9);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_haddr == 32'h1010, "R9 reload after accept", out_haddr, 32'h1010);
    chk(out_nmi == 1'b1, "R9 nmi", 32'(out_nmi), 32'h1);

    // R4 disabled input drops out
    @(negedge clk); irq_i = 8'b0000_0101;
    wr(7'h00, 32'h0000_00FB);
    rd(7'h02, 32'h0000_1000, "R4 disabled input ignored");

    // R9 idle: nothing pending
    @(negedge clk); irq_i = '0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid drops", 32'(out_valid), 32'h0);
    chk(irq_pending == 1'b0, "R8 pending low", 32'(irq_pending), 32'h0);

    // R7 chain merging
    @(negedge clk);
    irq_i = 8'b0000_0001;
    chain_valid = 1'b1; chain_level = 6'd7; chain_nmi = 1'b0;
    chain_rset = 6'd2; chain_haddr = 32'hABC0;
    rd(7'h02, 32'h0000_1000, "R7 chain disabled");
    wr(7'h01, 32'h1);
    rd(7'h01, 32'h1, "R7 control readback");
    rd(7'h02, 32'h0000_ABC0, "R7 chain wins");
    settle();
    chk(out_haddr == 32'hABC0, "R7 chain on stream", out_haddr, 32'hABC0);
    chk(out_rset == 6'd2, "R7 chain rset", 32'(out_rset), 32'd2);
    @(negedge clk); chain_level = 6'd5;
    rd(7'h02, 32'h0000_1000, "R7 tie keeps local");
    @(negedge clk); irq_i = '0; chain_level = 6'd0;
    #1 chk(irq_pending == 1'b0, "R7 chain level zero", 32'(irq_pending), 32'h0);
    @(negedge clk); chain_level = 6'd3;
    #1 chk(irq_pending == 1'b1, "R8 chain alone pending", 32'(irq_pending), 32'h1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    summary();
  end
endmodule